// File: doc/BRIEF.md
# Two-Slot Delayed-Branch Fetch Sequencer

This block generates the fetch address and the per-instruction kill control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Branches resolve in the execute stage, and the architecture gives every branch two delay slots. By the time a branch resolves, the two instructions after it are already in decode and fetch. They always run, and fetch moves to the target on the next cycle with no bubble.

The "likely" form of a branch annuls its two slot instructions when it is not taken. An annulled instruction travels down the pipe with its kill bit set, and the kill bit gates its write enable and its exception valid. The sequencer carries a small tag for each instruction in decode and execute: its address, whether it sits in a delay slot, and the address of the branch that owns the slot.

When a live instruction in execute raises an exception, the sequencer records a restart address. For a slot instruction that address is the owning branch, so the branch is replayed. Fetch then goes to a fixed handler vector. A return request sends fetch to a supplied address. Both events flush the two younger instructions.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While reset is high, and at the first sample after it falls, fetch_pc equals BOOT_ADDR, annul_mask is 2'b11 (both tracked stages empty), epc is 0 and epc_slot is 0.
- R2: In a cycle with no taken branch, no exception and no return accepted, fetch_pc advances by 4 on the next clock.
- R3: A live branch with br_taken=1 and br_likely=0 sets fetch_pc to br_target on the next clock. Its two slot instructions are not annulled. annul_mask bit 1 is the execute stage and bit 0 is the decode stage.
- R4: A live branch with br_taken=0 and br_likely=0 leaves sequential fetch unchanged and does not annul its two slot instructions.
- R5: A live branch with br_likely=1 and br_taken=0 annuls both slot instructions. On the next clock annul_mask is 2'b11, and on the clock after that bit 1 is still set.
- R6: A live branch with br_likely=1 and br_taken=1 behaves as R3: it redirects to br_target and keeps both slot instructions live.
- R7: br_valid, exc_req and ret_req are ignored while the execute-stage instruction is annulled. fetch_pc keeps its sequence and epc and epc_slot are unchanged.
- R8: A live exception on an instruction outside a delay slot sets fetch_pc to VEC_ADDR on the next clock, sets epc to that instruction's address with epc_slot=0, and sets annul_mask to 2'b11.
- R9: A live exception on either delay-slot instruction sets epc to the address of the owning branch and sets epc_slot=1.
- R10: A live return request sets fetch_pc to ret_pc on the next clock and annuls the two younger instructions (annul_mask 2'b11).
- R11: slot_err is high in the same cycle as a live branch whose own instruction sits in a delay slot, and low otherwise.
- R12: When an exception and a taken branch are accepted in the same cycle, the exception wins. fetch_pc becomes VEC_ADDR and epc holds the branch's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Instruction in execute is a resolved branch |
| br_taken | input | 1 | Branch outcome |
| br_likely | input | 1 | Branch is the likely form (annuls slots when not taken) |
| br_target | input | 32 | Branch target address |
| exc_req | input | 1 | Instruction in execute raises an exception (including one carried from its fetch) |
| ret_req | input | 1 | Instruction in execute is an exception return |
| ret_pc | input | 32 | Return address |
| fetch_pc | output | 32 | Address fetched this cycle |
| annul_mask | output | 2 | Kill bits: bit 1 execute stage, bit 0 decode stage |
| epc | output | 32 | Recorded restart address |
| epc_slot | output | 1 | Recorded fault was in a delay slot |
| slot_err | output | 1 | Branch placed in a delay slot (undefined case) |

## Verification
A slot or kill bit wrongly carried in a tag shows up one or two cycles later, when that instruction reaches execute. It appears as a wrong annul_mask bit, as an exception or branch that is acted on when it should be ignored, or as an epc pointing at the slot instead of the branch. A bad redirect choice shows as a wrong fetch_pc on the very next clock. A behavioural model tracks the two-instruction window and compares all registered outputs every cycle, and slot_err just after each input change. Directed sequences place exceptions on the first and the second slot, and place branches on annulled instructions.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int FS_AW    = 32;
    localparam int FS_STEP  = 4;
    localparam int FS_TRACK = 2;

    typedef logic [FS_AW-1:0] addr_t;

    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_RET = 2'd2,
        SRC_EXC = 2'd3
    } src_e;

    typedef struct packed {
        addr_t pc;
        addr_t owner;
        logic  in_slot;
        logic  kill;
    } tag_t;

    localparam tag_t TAG_EMPTY = '{pc: '0, owner: '0, in_slot: 1'b0, kill: 1'b1};

    function automatic addr_t seq_next(input addr_t a);
        return a + addr_t'(FS_STEP);
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  tag_t ex_tag,
    input  logic br_valid,
    input  logic br_taken,
    input  logic br_likely,
    input  logic exc_req,
    input  logic ret_req,
    output src_e src,
    output logic exc_go,
    output logic flush,
    output logic annul_slots,
    output logic mark_slot,
    output logic slot_err
);
    logic live, br_go, ret_go;

    always_comb begin
        live        = ~ex_tag.kill;
        br_go       = br_valid & live;
        exc_go      = exc_req & live;
        ret_go      = ret_req & live;
        flush       = exc_go | ret_go;
        mark_slot   = br_go;
        annul_slots = br_go & br_likely & ~br_taken;
        slot_err    = br_go & ex_tag.in_slot;
        if (exc_go)
            src = SRC_EXC;
        else if (ret_go)
            src = SRC_RET;
        else if (br_go && br_taken)
            src = SRC_BR;
        else
            src = SRC_SEQ;
    end
endmodule

// File: rtl/fseq_pc_gen.sv
module fseq_pc_gen
    import fseq_pkg::*;
#(
    parameter addr_t BOOT_ADDR = 32'h0000_1000,
    parameter addr_t VEC_ADDR  = 32'h0000_0080
) (
    input  logic  clk,
    input  logic  rst,
    input  src_e  src,
    input  addr_t br_target,
    input  addr_t ret_pc,
    output addr_t fetch_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc <= BOOT_ADDR;
        end else begin
            unique case (src)
                SRC_EXC: fetch_pc <= VEC_ADDR;
                SRC_RET: fetch_pc <= ret_pc;
                SRC_BR:  fetch_pc <= br_target;
                default: fetch_pc <= seq_next(fetch_pc);
            endcase
        end
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_SEQ) |=> (fetch_pc == $past(fetch_pc) + addr_t'(FS_STEP)));

    p_vector_r8: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_EXC) |=> (fetch_pc == VEC_ADDR));

    p_return_r10: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_RET) |=> (fetch_pc == $past(ret_pc)));
endmodule

// File: rtl/fseq_tag_pipe.sv
module fseq_tag_pipe
    import fseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t fetch_pc,
    input  logic  mark_slot,
    input  logic  flush,
    input  logic  annul_slots,
    output tag_t  id_tag,
    output tag_t  ex_tag
);
    tag_t id_n, ex_n;
    logic kill_young;

    always_comb begin
        kill_young    = flush | annul_slots;
        id_n.pc       = fetch_pc;
        id_n.in_slot  = mark_slot;
        id_n.owner    = mark_slot ? ex_tag.pc : '0;
        id_n.kill     = kill_young;
        ex_n          = id_tag;
        if (mark_slot) begin
            ex_n.in_slot = 1'b1;
            ex_n.owner   = ex_tag.pc;
        end
        ex_n.kill     = id_tag.kill | kill_young;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_tag <= TAG_EMPTY;
            ex_tag <= TAG_EMPTY;
        end else begin
            id_tag <= id_n;
            ex_tag <= ex_n;
        end
    end

    p_annul_both_r5: assert property (@(posedge clk) disable iff (rst)
        annul_slots |=> (id_tag.kill && ex_tag.kill));

    p_annul_second_r5: assert property (@(posedge clk) disable iff (rst)
        annul_slots |=> ##1 ex_tag.kill);

    p_flush_young_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (id_tag.kill && ex_tag.kill));

    p_slot_owner_r9: assert property (@(posedge clk) disable iff (rst)
        (mark_slot && !flush) |=> (ex_tag.in_slot && ex_tag.owner == $past(ex_tag.pc)));
endmodule

// File: rtl/fseq_exc_rec.sv
module fseq_exc_rec
    import fseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  exc_go,
    input  tag_t  ex_tag,
    output addr_t epc,
    output logic  epc_slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc      <= '0;
            epc_slot <= 1'b0;
        end else if (exc_go) begin
            epc      <= ex_tag.in_slot ? ex_tag.owner : ex_tag.pc;
            epc_slot <= ex_tag.in_slot;
        end
    end

    p_slot_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_go && ex_tag.in_slot) |=> (epc_slot && epc == $past(ex_tag.owner)));

    p_plain_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_go && !ex_tag.in_slot) |=> (!epc_slot && epc == $past(ex_tag.pc)));

    p_epc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !exc_go |=> ($stable(epc) && $stable(epc_slot)));
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
    import fseq_pkg::*;
#(
    parameter addr_t BOOT_ADDR = 32'h0000_1000,
    parameter addr_t VEC_ADDR  = 32'h0000_0080
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                br_valid,
    input  logic                br_taken,
    input  logic                br_likely,
    input  logic [FS_AW-1:0]    br_target,
    input  logic                exc_req,
    input  logic                ret_req,
    input  logic [FS_AW-1:0]    ret_pc,
    output logic [FS_AW-1:0]    fetch_pc,
    output logic [FS_TRACK-1:0] annul_mask,
    output logic [FS_AW-1:0]    epc,
    output logic                epc_slot,
    output logic                slot_err
);
    tag_t id_tag, ex_tag;
    src_e src;
    logic exc_go, flush, annul_slots, mark_slot;

    fseq_ctrl u_ctrl (
        .ex_tag      (ex_tag),
        .br_valid    (br_valid),
        .br_taken    (br_taken),
        .br_likely   (br_likely),
        .exc_req     (exc_req),
        .ret_req     (ret_req),
        .src         (src),
        .exc_go      (exc_go),
        .flush       (flush),
        .annul_slots (annul_slots),
        .mark_slot   (mark_slot),
        .slot_err    (slot_err)
    );

    fseq_pc_gen #(.BOOT_ADDR(BOOT_ADDR), .VEC_ADDR(VEC_ADDR)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .br_target (br_target),
        .ret_pc    (ret_pc),
        .fetch_pc  (fetch_pc)
    );

    fseq_tag_pipe u_tags (
        .clk         (clk),
        .rst         (rst),
        .fetch_pc    (fetch_pc),
        .mark_slot   (mark_slot),
        .flush       (flush),
        .annul_slots (annul_slots),
        .id_tag      (id_tag),
        .ex_tag      (ex_tag)
    );

    fseq_exc_rec u_exc (
        .clk      (clk),
        .rst      (rst),
        .exc_go   (exc_go),
        .ex_tag   (ex_tag),
        .epc      (epc),
        .epc_slot (epc_slot)
    );

    assign annul_mask = {ex_tag.kill, id_tag.kill};

    p_dead_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ex_tag.kill |-> (!exc_go && !flush && !mark_slot));

    p_err_needs_branch_r11: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> (br_valid && !ex_tag.kill));

    p_exc_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (exc_go && br_valid && br_taken) |=> (fetch_pc == VEC_ADDR));

    p_live_branch_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (mark_slot && !annul_slots && !flush) |=> (annul_mask[1] == 1'b0));
endmodule

// File: tb/sim_dslot_fetch_seq.sv
module sim_dslot_fetch_seq;
    localparam logic [31:0] BOOT = 32'h0000_1000;
    localparam logic [31:0] VEC  = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 0, br_taken = 0, br_likely = 0, exc_req = 0, ret_req = 0;
    logic [31:0] br_target = '0, ret_pc = '0;
    logic [31:0] fetch_pc, epc;
    logic [1:0]  annul_mask;
    logic        epc_slot, slot_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";
    logic  err_seen;

    // behavioural reference state: the fetch address and the two-instruction window
    logic [31:0] m_fpc;
    logic [31:0] m_dec_pc, m_dec_own, m_exe_pc, m_exe_own;
    logic        m_dec_slot, m_dec_dead, m_exe_slot, m_exe_dead;
    logic [31:0] m_epc;
    logic        m_eslot;

    dslot_fetch_seq #(.BOOT_ADDR(BOOT), .VEC_ADDR(VEC)) u0 (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
        .br_likely(br_likely), .br_target(br_target), .exc_req(exc_req),
        .ret_req(ret_req), .ret_pc(ret_pc), .fetch_pc(fetch_pc),
        .annul_mask(annul_mask), .epc(epc), .epc_slot(epc_slot), .slot_err(slot_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_fpc = BOOT;
        m_dec_pc = '0; m_dec_own = '0; m_dec_slot = 0; m_dec_dead = 1;
        m_exe_pc = '0; m_exe_own = '0; m_exe_slot = 0; m_exe_dead = 1;
        m_epc = '0; m_eslot = 0;
    endtask

    task automatic compare_all();
        chk({cur_req, " fetch_pc"}, fetch_pc, m_fpc);
        chk({cur_req, " annul_mask"}, {30'd0, annul_mask}, {30'd0, m_exe_dead, m_dec_dead});
        chk({cur_req, " epc"}, epc, m_epc);
        chk({cur_req, " epc_slot"}, {31'd0, epc_slot}, {31'd0, m_eslot});
    endtask

    // one cycle: drive at the falling edge, check combinational flag, advance model at the rising edge
    task automatic cyc(input logic b, input logic t, input logic l, input logic [31:0] tg,
                       input logic e, input logic r, input logic [31:0] rp);
        logic bg, eg, rg, kill_new, exp_err;
        logic [31:0] nf;
        br_valid = b; br_taken = t; br_likely = l; br_target = tg;
        exc_req = e; ret_req = r; ret_pc = rp;
        bg = b && !m_exe_dead;
        eg = e && !m_exe_dead;
        rg = r && !m_exe_dead;
        exp_err = bg && m_exe_slot;
        #1;
        err_seen = slot_err;
        chk({cur_req, " slot_err"}, {31'd0, slot_err}, {31'd0, exp_err});
        if (eg)             nf = VEC;
        else if (rg)        nf = rp;
        else if (bg && t)   nf = tg;
        else                nf = m_fpc + 32'd4;
        kill_new = eg || rg || (bg && l && !t);
        @(posedge clk);
        if (eg) begin
            m_epc   = m_exe_slot ? m_exe_own : m_exe_pc;
            m_eslot = m_exe_slot;
        end
        m_exe_pc   = m_dec_pc;
        m_exe_own  = bg ? m_exe_pc_prev(m_exe_pc) : m_dec_own;
        m_exe_slot = bg ? 1'b1 : m_dec_slot;
        m_exe_dead = m_dec_dead || kill_new;
        m_dec_pc   = m_fpc;
        m_dec_slot = bg;
        m_dec_own  = bg ? m_exe_pc_prev(m_exe_pc) : 32'd0;
        m_dec_dead = kill_new;
        m_fpc      = nf;
        @(negedge clk);
        br_valid = 0; exc_req = 0; ret_req = 0;
        compare_all();
    endtask

    // the branch owner is the address that was in execute before the shift
    logic [31:0] owner_hold;
    function automatic logic [31:0] m_exe_pc_prev(input logic [31:0] dummy);
        return owner_hold;
    endfunction

    task automatic step(input logic b, input logic t, input logic l, input logic [31:0] tg,
                        input logic e, input logic r, input logic [31:0] rp);
        owner_hold = m_exe_pc;
        cyc(b, t, l, tg, e, r, rp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] bpc;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: held reset values
        cur_req = "R1";
        chk("R1 boot fetch", fetch_pc, BOOT);
        chk("R1 empty mask", {30'd0, annul_mask}, 32'd3);
        chk("R1 epc", epc, 32'd0);
        chk("R1 epc_slot", {31'd0, epc_slot}, 32'd0);
        rst = 0;
        compare_all();

        // R2: sequential stepping
        cur_req = "R2";
        idle(3);
        chk("R2 step by 4", fetch_pc, BOOT + 32'd12);

        // R3: normal taken branch, slots live, no bubble
        cur_req = "R3";
        step(1, 1, 0, 32'h0000_2000, 0, 0, 0);
        chk("R3 target", fetch_pc, 32'h0000_2000);
        chk("R3 slots live", {30'd0, annul_mask}, 32'd0);
        chk("R3 no slot_err", {31'd0, err_seen}, 32'd0);
        idle(1);
        chk("R3 second slot live", {31'd0, annul_mask[1]}, 32'd0);
        idle(2);

        // R4: normal not-taken branch
        cur_req = "R4";
        step(1, 0, 0, 32'h0000_9990, 0, 0, 0);
        chk("R4 fall through", fetch_pc, 32'h0000_2000 + 32'd16);
        chk("R4 slots live", {30'd0, annul_mask}, 32'd0);
        idle(3);

        // R5: likely, not taken -> both slots annulled
        cur_req = "R5";
        step(1, 0, 1, 32'h0000_9990, 0, 0, 0);
        chk("R5 both annulled", {30'd0, annul_mask}, 32'd3);
        // R7: annulled slot in execute raises an exception -> ignored
        cur_req = "R7";
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R7 exception ignored fetch", fetch_pc == VEC ? 32'd1 : 32'd0, 32'd0);
        chk("R7 epc untouched", epc, 32'd0);
        chk("R5 second slot annulled", {31'd0, annul_mask[1]}, 32'd1);
        // R7: annulled second slot claims a taken branch and a return -> ignored
        step(1, 1, 0, 32'h0000_3000, 0, 1, 32'h0000_3100);
        chk("R7 branch ignored", fetch_pc == 32'h0000_3000 ? 32'd1 : 32'd0, 32'd0);
        chk("R7 return ignored", fetch_pc == 32'h0000_3100 ? 32'd1 : 32'd0, 32'd0);
        idle(3);

        // R6: likely, taken -> like a normal taken branch
        cur_req = "R6";
        step(1, 1, 1, 32'h0000_4000, 0, 0, 0);
        chk("R6 target", fetch_pc, 32'h0000_4000);
        chk("R6 slots live", {30'd0, annul_mask}, 32'd0);
        idle(3);

        // R9: exception on first slot
        cur_req = "R9";
        bpc = m_exe_pc;
        step(1, 1, 0, 32'h0000_5000, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R9 slot1 epc is branch", epc, bpc);
        chk("R9 slot1 flag", {31'd0, epc_slot}, 32'd1);
        chk("R9 vector", fetch_pc, VEC);
        idle(3);
        // R9: exception on second slot
        bpc = m_exe_pc;
        step(1, 1, 0, 32'h0000_6000, 0, 0, 0);
        idle(1);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R9 slot2 epc is branch", epc, bpc);
        chk("R9 slot2 flag", {31'd0, epc_slot}, 32'd1);
        idle(3);

        // R8: exception outside a slot
        cur_req = "R8";
        bpc = m_exe_pc;
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R8 epc", epc, bpc);
        chk("R8 flag clear", {31'd0, epc_slot}, 32'd0);
        chk("R8 vector", fetch_pc, VEC);
        chk("R8 flush", {30'd0, annul_mask}, 32'd3);
        idle(3);

        // R10: return
        cur_req = "R10";
        step(0, 0, 0, 0, 0, 1, 32'h0001_2340);
        chk("R10 return addr", fetch_pc, 32'h0001_2340);
        chk("R10 flush", {30'd0, annul_mask}, 32'd3);
        idle(3);

        // R11: branch placed in a delay slot
        cur_req = "R11";
        step(1, 1, 0, 32'h0000_7000, 0, 0, 0);
        chk("R11 clean branch", {31'd0, err_seen}, 32'd0);
        step(1, 1, 0, 32'h0000_7100, 0, 0, 0);
        chk("R11 flagged", {31'd0, err_seen}, 32'd1);
        idle(4);

        // R12: exception and taken branch in the same cycle
        cur_req = "R12";
        bpc = m_exe_pc;
        step(1, 1, 0, 32'h0000_8000, 1, 0, 0);
        chk("R12 vector wins", fetch_pc, VEC);
        chk("R12 epc is branch", epc, bpc);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule